// File: doc/BRIEF.md
# External Register Field Responder

This block is the hardware-side target for a 32-bit register that is kept outside a register bank. The register is split into two 16-bit fields, low and high. For each field the bank raises a write request or a read request and holds it until the field acknowledges. Write data arrives together with a per-bit write mask, and each field answers on its own ack and error lines and returns its full stored value.

The low field can also be reached through a second, aliased view of the register. That view has its own request, data and mask wires, but its answer comes back on the low field's normal ack, error and data lines. A completion stage combines the field answers into one done/error/read-word result for the current view. In the aliased view the upper half of the read word is zero.

The test environment controls the handshake through two inputs. A wait count of 0 to 15 cycles stretches the time from request to ack, and a per-field inject input forces an error on that field's next access.

Top module: `ext_field_responder`

## Requirements
- R1: With the wait count at W, a request first sampled at clock edge k raises the matching ack after edge k+W, so the ack is first visible W+1 cycles after the request was driven. The wait count is read when the request is first seen.
- R2: Once raised, an ack stays high while its request is high and drops on the first clock edge that samples the request low.
- R3: A write changes only stored bits whose mask bit is 1. The mask for the low field is {{8{be[1]}},{8{be[0]}}} and for the high field {{8{be[3]}},{8{be[2]}}}.
- R4: A read returns the full 32-bit stored word whatever the byte enables are.
- R5: An aliased write, on the alias wires, updates the low field through its mask and answers on the low field's write ack and error lines. The high field is not touched.
- R6: An aliased read returns {16'h0000, low field} on the completion read word.
- R7: In the main view, completion (reg_done) is high only while both fields acknowledge the same kind of access. In the aliased view it follows the low field's ack alone.
- R8: Completion reports an error when no byte enable of the view is set (all four in the main view, be[1:0] in the aliased view), or when an acknowledging field reports an error. reg_err is never high without reg_done.
- R9: A pulse on a field's error-inject input makes that field's next access acknowledge with its error line high. The error stays high for the whole ack and clears when the ack drops. An errored write leaves that field's stored value unchanged, and the following access is error-free.
- R10: A synchronous active-low reset clears both fields to zero and drops all acks and errors on the next clock edge.
- R11: A request withdrawn before its ack is raised produces no ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wait_cycles | input | 4 | Extra cycles between request and ack |
| err_inject | input | 2 | Per-field error injection, bit 0 low field, bit 1 high field |
| lo_wr_req | input | 1 | Low field write request |
| lo_rd_req | input | 1 | Low field read request |
| lo_wr_data | input | 16 | Low field write data |
| lo_wr_mask | input | 16 | Low field bitwise write mask |
| hi_wr_req | input | 1 | High field write request |
| hi_rd_req | input | 1 | High field read request |
| hi_wr_data | input | 16 | High field write data |
| hi_wr_mask | input | 16 | High field bitwise write mask |
| al_wr_req | input | 1 | Aliased-view write request to the low field |
| al_rd_req | input | 1 | Aliased-view read request to the low field |
| al_wr_data | input | 16 | Aliased-view write data |
| al_wr_mask | input | 16 | Aliased-view bitwise write mask |
| acc_be | input | 4 | Byte enables of the current access |
| acc_alias | input | 1 | Current access uses the aliased view |
| lo_wr_ack | output | 1 | Low field write acknowledge |
| lo_rd_ack | output | 1 | Low field read acknowledge |
| lo_wr_err | output | 1 | Low field write error |
| lo_rd_err | output | 1 | Low field read error |
| lo_rd_data | output | 16 | Low field stored value |
| hi_wr_ack | output | 1 | High field write acknowledge |
| hi_rd_ack | output | 1 | High field read acknowledge |
| hi_wr_err | output | 1 | High field write error |
| hi_rd_err | output | 1 | High field read error |
| hi_rd_data | output | 16 | High field stored value |
| reg_done | output | 1 | Register-level completion |
| reg_err | output | 1 | Register-level error |
| reg_rdata | output | 32 | Read word for the current view |

## Verification
The bench sweeps every wait count against every byte-enable pattern, so a counter that is off by one shows up as a latency error. A mask built with the wrong byte order leaves bits wrong on read-back, and a missing no-enable error is caught as well. Aliased writes are checked by reading back through the main view, because a design that routed the alias into the high field, or wrote both halves, corrupts the untouched half. Injected errors are checked while the ack is held and on the access after, which catches a flag that drops early, sticks, or lets the errored write through. A request withdrawn during a long wait and a reset in mid-run catch a responder that acks on its own or keeps state through reset.

// File: rtl/ext_resp_pkg.sv
// Package: shared widths and the handshake state type for the external
// field responder. Assumes byte-granular fields (width a multiple of 8).
package ext_resp_pkg;
    localparam int unsigned FIELD_W_DEF = 16;
    localparam int unsigned WAIT_W_DEF  = 4;

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_ACK  = 2'd2
    } slot_state_e;
endpackage

// File: rtl/ext_field_slot.sv
// Module: one field of the external register. It stores FIELD_W bits and runs
// a four-phase handshake for writes and reads. The optional alias path feeds
// the same storage and answers on the same ack/error lines.
// Assumes: the bank raises at most one request per field at a time and keeps
// request, data and mask stable until the ack.
module ext_field_slot
    import ext_resp_pkg::*;
#(
    parameter int unsigned FIELD_W   = 16,
    parameter int unsigned WAIT_W    = 4,
    parameter bit          HAS_ALIAS = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WAIT_W-1:0]  wait_cycles,
    input  logic               err_inject,
    input  logic               wr_req,
    input  logic               rd_req,
    input  logic [FIELD_W-1:0] wr_data,
    input  logic [FIELD_W-1:0] wr_mask,
    input  logic               al_wr_req,
    input  logic               al_rd_req,
    input  logic [FIELD_W-1:0] al_wr_data,
    input  logic [FIELD_W-1:0] al_wr_mask,
    output logic               wr_ack,
    output logic               rd_ack,
    output logic               wr_err,
    output logic               rd_err,
    output logic [FIELD_W-1:0] rd_data
);
    slot_state_e        state_q;
    logic [WAIT_W-1:0]  cnt_q;
    logic               is_wr_q;
    logic               ack_q;
    logic               err_q;
    logic               pend_q;
    logic [FIELD_W-1:0] store_q;

    logic               any_wr;
    logic               any_rd;
    logic [FIELD_W-1:0] sel_data;
    logic [FIELD_W-1:0] sel_mask;
    logic               kind_wr_now;
    logic               kind_req;
    logic               raise_now;
    logic [FIELD_W-1:0] merged;

    // Pick the request sources: the main wires alone, or main and alias combined.
    generate
        if (HAS_ALIAS) begin : g_alias
            assign any_wr   = wr_req | al_wr_req;
            assign any_rd   = rd_req | al_rd_req;
            assign sel_data = al_wr_req ? al_wr_data : wr_data;
            assign sel_mask = al_wr_req ? al_wr_mask : wr_mask;
        end else begin : g_plain
            logic unused_alias;
            assign unused_alias = ^{al_wr_req, al_rd_req, al_wr_data, al_wr_mask};
            assign any_wr   = wr_req;
            assign any_rd   = rd_req;
            assign sel_data = wr_data;
            assign sel_mask = wr_mask;
        end
    endgenerate

    // Decide the access kind and whether the ack rises at this edge.
    always_comb begin
        kind_wr_now = (state_q == SLOT_IDLE) ? any_wr : is_wr_q;
        kind_req    = kind_wr_now ? any_wr : any_rd;
        raise_now   = ((state_q == SLOT_IDLE) && (any_wr || any_rd) && (wait_cycles == '0))
                   || ((state_q == SLOT_WAIT) && kind_req && (cnt_q == '0));
        merged      = (store_q & ~sel_mask) | (sel_data & sel_mask);
    end

    // Handshake sequencing: idle, count the wait, then hold the ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
            cnt_q   <= '0;
            is_wr_q <= 1'b0;
            ack_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                SLOT_IDLE: begin
                    if (any_wr || any_rd) begin
                        is_wr_q <= any_wr;
                        if (raise_now) begin
                            state_q <= SLOT_ACK;
                            ack_q   <= 1'b1;
                            err_q   <= pend_q;
                        end else begin
                            state_q <= SLOT_WAIT;
                            cnt_q   <= wait_cycles - 1'b1;
                        end
                    end
                end
                SLOT_WAIT: begin
                    if (!kind_req) begin
                        state_q <= SLOT_IDLE;
                    end else if (raise_now) begin
                        state_q <= SLOT_ACK;
                        ack_q   <= 1'b1;
                        err_q   <= pend_q;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                SLOT_ACK: begin
                    if (!kind_req) begin
                        state_q <= SLOT_IDLE;
                        ack_q   <= 1'b0;
                        err_q   <= 1'b0;
                    end
                end
                default: begin
                    state_q <= SLOT_IDLE;
                    ack_q   <= 1'b0;
                    err_q   <= 1'b0;
                end
            endcase
        end
    end

    // Pending error: set by the inject input, consumed when an ack rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (err_inject) begin
            pend_q <= 1'b1;
        end else if (raise_now) begin
            pend_q <= 1'b0;
        end
    end

    // Field storage: the masked write commits at the ack edge unless it errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (raise_now && kind_wr_now && !pend_q) begin
            store_q <= merged;
        end
    end

    // Split the shared ack and error onto the write and read lines.
    always_comb begin
        wr_ack  = ack_q & is_wr_q;
        rd_ack  = ack_q & ~is_wr_q;
        wr_err  = err_q & is_wr_q;
        rd_err  = err_q & ~is_wr_q;
        rd_data = store_q;
    end
endmodule

// File: rtl/ext_done_merge.sv
// Module: register-level completion. It joins the field acks and errors for
// the current view (main or alias) and builds the read word for that view.
// Assumes: the byte enables and the view select stay stable through the access.
module ext_done_merge #(
    parameter int unsigned FIELD_W = 16
) (
    input  logic                 lo_wr_ack,
    input  logic                 lo_rd_ack,
    input  logic                 hi_wr_ack,
    input  logic                 hi_rd_ack,
    input  logic                 lo_err,
    input  logic                 hi_err,
    input  logic [FIELD_W-1:0]   lo_data,
    input  logic [FIELD_W-1:0]   hi_data,
    input  logic [FIELD_W/4-1:0] acc_be,
    input  logic                 acc_alias,
    output logic                 reg_done,
    output logic                 reg_err,
    output logic [2*FIELD_W-1:0] reg_rdata
);
    localparam int unsigned BPF = FIELD_W / 8;

    logic main_done;
    logic alias_done;
    logic main_bad;
    logic alias_bad;

    // Completion and error for each view, then select the active view.
    always_comb begin
        main_done  = (lo_wr_ack && hi_wr_ack) || (lo_rd_ack && hi_rd_ack);
        alias_done = lo_wr_ack || lo_rd_ack;
        main_bad   = (acc_be == '0) || lo_err || hi_err;
        alias_bad  = (acc_be[BPF-1:0] == '0) || lo_err;
        if (acc_alias) begin
            reg_done  = alias_done;
            reg_err   = alias_done && alias_bad;
            reg_rdata = {{FIELD_W{1'b0}}, lo_data};
        end else begin
            reg_done  = main_done;
            reg_err   = main_done && main_bad;
            reg_rdata = {hi_data, lo_data};
        end
    end
endmodule

// File: rtl/ext_field_responder.sv
// Module: top of the external register responder. Two field slots (the low one
// also serves the alias view) and a completion stage.
// Assumes: the bank drives requests per field and keeps them until acked.
module ext_field_responder
    import ext_resp_pkg::*;
#(
    parameter int unsigned FIELD_W = FIELD_W_DEF,
    parameter int unsigned WAIT_W  = WAIT_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WAIT_W-1:0]    wait_cycles,
    input  logic [1:0]           err_inject,
    input  logic                 lo_wr_req,
    input  logic                 lo_rd_req,
    input  logic [FIELD_W-1:0]   lo_wr_data,
    input  logic [FIELD_W-1:0]   lo_wr_mask,
    input  logic                 hi_wr_req,
    input  logic                 hi_rd_req,
    input  logic [FIELD_W-1:0]   hi_wr_data,
    input  logic [FIELD_W-1:0]   hi_wr_mask,
    input  logic                 al_wr_req,
    input  logic                 al_rd_req,
    input  logic [FIELD_W-1:0]   al_wr_data,
    input  logic [FIELD_W-1:0]   al_wr_mask,
    input  logic [FIELD_W/4-1:0] acc_be,
    input  logic                 acc_alias,
    output logic                 lo_wr_ack,
    output logic                 lo_rd_ack,
    output logic                 lo_wr_err,
    output logic                 lo_rd_err,
    output logic [FIELD_W-1:0]   lo_rd_data,
    output logic                 hi_wr_ack,
    output logic                 hi_rd_ack,
    output logic                 hi_wr_err,
    output logic                 hi_rd_err,
    output logic [FIELD_W-1:0]   hi_rd_data,
    output logic                 reg_done,
    output logic                 reg_err,
    output logic [2*FIELD_W-1:0] reg_rdata
);
    // Low field: serves main and alias requests.
    ext_field_slot #(.FIELD_W(FIELD_W), .WAIT_W(WAIT_W), .HAS_ALIAS(1'b1)) u_lo (
        .clk(clk), .rst_n(rst_n), .wait_cycles(wait_cycles), .err_inject(err_inject[0]),
        .wr_req(lo_wr_req), .rd_req(lo_rd_req), .wr_data(lo_wr_data), .wr_mask(lo_wr_mask),
        .al_wr_req(al_wr_req), .al_rd_req(al_rd_req),
        .al_wr_data(al_wr_data), .al_wr_mask(al_wr_mask),
        .wr_ack(lo_wr_ack), .rd_ack(lo_rd_ack), .wr_err(lo_wr_err), .rd_err(lo_rd_err),
        .rd_data(lo_rd_data)
    );

    // High field: main view only, alias inputs tied off.
    ext_field_slot #(.FIELD_W(FIELD_W), .WAIT_W(WAIT_W), .HAS_ALIAS(1'b0)) u_hi (
        .clk(clk), .rst_n(rst_n), .wait_cycles(wait_cycles), .err_inject(err_inject[1]),
        .wr_req(hi_wr_req), .rd_req(hi_rd_req), .wr_data(hi_wr_data), .wr_mask(hi_wr_mask),
        .al_wr_req(1'b0), .al_rd_req(1'b0),
        .al_wr_data('0), .al_wr_mask('0),
        .wr_ack(hi_wr_ack), .rd_ack(hi_rd_ack), .wr_err(hi_wr_err), .rd_err(hi_rd_err),
        .rd_data(hi_rd_data)
    );

    // Register-level completion for the active view.
    ext_done_merge #(.FIELD_W(FIELD_W)) u_merge (
        .lo_wr_ack(lo_wr_ack), .lo_rd_ack(lo_rd_ack),
        .hi_wr_ack(hi_wr_ack), .hi_rd_ack(hi_rd_ack),
        .lo_err(lo_wr_err | lo_rd_err), .hi_err(hi_wr_err | hi_rd_err),
        .lo_data(lo_rd_data), .hi_data(hi_rd_data),
        .acc_be(acc_be), .acc_alias(acc_alias),
        .reg_done(reg_done), .reg_err(reg_err), .reg_rdata(reg_rdata)
    );
endmodule

// File: rtl/ext_field_responder_chk.sv
// Checker: handshake and storage properties of the responder, bound to the top.
module ext_field_responder_chk #(
    parameter int unsigned FIELD_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lo_wr_req,
    input logic               lo_rd_req,
    input logic               al_wr_req,
    input logic               al_rd_req,
    input logic               hi_wr_req,
    input logic [FIELD_W-1:0] hi_wr_data,
    input logic [FIELD_W-1:0] hi_wr_mask,
    input logic               lo_wr_ack,
    input logic               lo_rd_ack,
    input logic               lo_wr_err,
    input logic               hi_wr_ack,
    input logic               hi_wr_err,
    input logic [FIELD_W-1:0] hi_rd_data,
    input logic [FIELD_W-1:0] lo_rd_data,
    input logic               reg_done,
    input logic               reg_err
);
    // R1
    lo_wr_ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_wr_ack) |-> $past(lo_wr_req || al_wr_req));
    // R1
    lo_rd_ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_rd_ack) |-> $past(lo_rd_req || al_rd_req));
    // R2
    hi_wr_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr_ack && hi_wr_req) |=> hi_wr_ack);
    // R2
    hi_wr_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr_ack && !hi_wr_req) |=> !hi_wr_ack);
    // R3
    hi_masked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hi_wr_ack) && !hi_wr_err) |->
        hi_rd_data == (($past(hi_wr_data) & $past(hi_wr_mask)) | ($past(hi_rd_data) & ~$past(hi_wr_mask))));
    // R9
    lo_err_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr_err |-> lo_wr_ack);
    // R9
    hi_err_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr_ack && $past(hi_wr_ack)) |-> $stable(hi_wr_err));
    // R8
    reg_err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> reg_done);
    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!lo_wr_ack && !hi_wr_ack && lo_rd_data == '0 && hi_rd_data == '0));
endmodule

bind ext_field_responder ext_field_responder_chk #(.FIELD_W(FIELD_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .lo_wr_req(lo_wr_req), .lo_rd_req(lo_rd_req),
    .al_wr_req(al_wr_req), .al_rd_req(al_rd_req),
    .hi_wr_req(hi_wr_req), .hi_wr_data(hi_wr_data), .hi_wr_mask(hi_wr_mask),
    .lo_wr_ack(lo_wr_ack), .lo_rd_ack(lo_rd_ack), .lo_wr_err(lo_wr_err),
    .hi_wr_ack(hi_wr_ack), .hi_wr_err(hi_wr_err),
    .hi_rd_data(hi_rd_data), .lo_rd_data(lo_rd_data),
    .reg_done(reg_done), .reg_err(reg_err)
);

// File: tb/ext_field_responder_bench.sv
module ext_field_responder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  wait_cycles = '0;
    logic [1:0]  err_inject = '0;
    logic        lo_wr_req = 0, lo_rd_req = 0, hi_wr_req = 0, hi_rd_req = 0;
    logic        al_wr_req = 0, al_rd_req = 0;
    logic [15:0] lo_wr_data = '0, lo_wr_mask = '0, hi_wr_data = '0, hi_wr_mask = '0;
    logic [15:0] al_wr_data = '0, al_wr_mask = '0;
    logic [3:0]  acc_be = '0;
    logic        acc_alias = 1'b0;
    logic        lo_wr_ack, lo_rd_ack, lo_wr_err, lo_rd_err;
    logic        hi_wr_ack, hi_rd_ack, hi_wr_err, hi_rd_err;
    logic [15:0] lo_rd_data, hi_rd_data;
    logic        reg_done, reg_err;
    logic [31:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [31:0] model = '0;

    always #4 clk = ~clk;

    ext_field_responder u_ext_field_responder (
        .clk(clk), .rst_n(rst_n), .wait_cycles(wait_cycles), .err_inject(err_inject),
        .lo_wr_req(lo_wr_req), .lo_rd_req(lo_rd_req), .lo_wr_data(lo_wr_data), .lo_wr_mask(lo_wr_mask),
        .hi_wr_req(hi_wr_req), .hi_rd_req(hi_rd_req), .hi_wr_data(hi_wr_data), .hi_wr_mask(hi_wr_mask),
        .al_wr_req(al_wr_req), .al_rd_req(al_rd_req), .al_wr_data(al_wr_data), .al_wr_mask(al_wr_mask),
        .acc_be(acc_be), .acc_alias(acc_alias),
        .lo_wr_ack(lo_wr_ack), .lo_rd_ack(lo_rd_ack), .lo_wr_err(lo_wr_err), .lo_rd_err(lo_rd_err),
        .lo_rd_data(lo_rd_data),
        .hi_wr_ack(hi_wr_ack), .hi_rd_ack(hi_rd_ack), .hi_wr_err(hi_wr_err), .hi_rd_err(hi_rd_err),
        .hi_rd_data(hi_rd_data),
        .reg_done(reg_done), .reg_err(reg_err), .reg_rdata(reg_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [15:0] merge16(input logic [15:0] old, input logic [15:0] d, input logic [15:0] m);
        return (old & ~m) | (d & m);
    endfunction

    task automatic drop_all();
        lo_wr_req = 0; lo_rd_req = 0; hi_wr_req = 0; hi_rd_req = 0;
        al_wr_req = 0; al_rd_req = 0;
    endtask

    // One access through the main or alias view; checks latency, hold, drop, error.
    task automatic access(input bit wr, input bit alias_v, input logic [31:0] d,
                          input logic [3:0] be, input logic [3:0] w, input bit exp_err,
                          output logic [31:0] rdata);
        int lat;
        @(negedge clk);
        wait_cycles = w; acc_be = be; acc_alias = alias_v;
        if (alias_v) begin
            al_wr_req = wr; al_rd_req = !wr;
            al_wr_data = d[15:0]; al_wr_mask = mk_mask(be[1:0]);
        end else begin
            lo_wr_req = wr; hi_wr_req = wr; lo_rd_req = !wr; hi_rd_req = !wr;
            lo_wr_data = d[15:0]; lo_wr_mask = mk_mask(be[1:0]);
            hi_wr_data = d[31:16]; hi_wr_mask = mk_mask(be[3:2]);
        end
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!reg_done && lat < 40);
        // R1 latency of ack after request
        check(lat == int'(w) + 1, "R1 latency", lat, int'(w) + 1);
        // R8 completion error
        check(reg_err == exp_err, "R8 error", reg_err, exp_err);
        rdata = reg_rdata;
        repeat (2) begin
            @(negedge clk);
            // R2 ack held while request high
            check(reg_done === 1'b1, "R2 hold", reg_done, 1);
        end
        drop_all();
        @(negedge clk);
        // R2 ack drops one edge after request drops
        check(!(lo_wr_ack | lo_rd_ack | hi_wr_ack | hi_rd_ack), "R2 drop",
              {lo_wr_ack, lo_rd_ack, hi_wr_ack, hi_rd_ack}, 0);
    endtask

    initial begin
        logic [31:0] rd;
        logic [31:0] d;
        repeat (4) @(negedge clk);
        // R10 reset state
        check(!(lo_wr_ack | lo_rd_ack | hi_wr_ack | hi_rd_ack | reg_done), "R10 acks", reg_done, 0);
        check({hi_rd_data, lo_rd_data} == 32'h0, "R10 data", {hi_rd_data, lo_rd_data}, 0);
        rst_n = 1'b1;

        // Sweep: every wait count against every byte-enable pattern (R1 R2 R3 R4 R8)
        for (int w = 0; w < 16; w++) begin
            for (int be = 0; be < 16; be++) begin
                d = 32'h9E37_79B9 * (w * 16 + be + 1);
                access(1'b1, 1'b0, d, 4'(be), 4'(w), be == 0, rd);
                model[15:0]  = merge16(model[15:0], d[15:0], mk_mask(2'(be)));
                model[31:16] = merge16(model[31:16], d[31:16], mk_mask(2'(be >> 2)));
                access(1'b0, 1'b0, 32'h0, ~4'(be), 4'(15 - w), be == 15, rd);
                // R3 masked write, R4 full read regardless of byte enables
                check(rd == model, "R3/R4 readback", rd, model);
            end
        end

        // R5 alias write touches only the low field
        for (int be = 1; be < 4; be++) begin
            d = 32'hFFFF_0000 | (32'h1357 * (be + 3));
            access(1'b1, 1'b1, d, 4'(be) | 4'hC, 4'(be), 1'b0, rd);
            model[15:0] = merge16(model[15:0], d[15:0], mk_mask(2'(be)));
            access(1'b0, 1'b0, 32'h0, 4'hF, 4'd0, 1'b0, rd);
            check(rd == model, "R5 alias write", rd, model);
            // R6 alias read: upper half zero
            access(1'b0, 1'b1, 32'h0, 4'h1, 4'd2, 1'b0, rd);
            check(rd == {16'h0, model[15:0]}, "R6 alias read", rd, {16'h0, model[15:0]});
        end
        // R8 alias view with no low byte enable reports error
        access(1'b0, 1'b1, 32'h0, 4'hC, 4'd1, 1'b1, rd);

        // R7 only the low field requested in the main view: no completion
        @(negedge clk);
        acc_alias = 1'b0; acc_be = 4'hF; wait_cycles = 4'd0;
        lo_wr_req = 1'b1; lo_wr_data = 16'hA5A5; lo_wr_mask = 16'h0000;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(!reg_done, "R7 partial ack", reg_done, 0);
        end
        check(lo_wr_ack === 1'b1, "R7 low acked", lo_wr_ack, 1);
        drop_all();
        @(negedge clk);

        // R9 error injection on the high field during a write
        @(negedge clk);
        err_inject = 2'b10;
        @(negedge clk);
        err_inject = 2'b00;
        @(negedge clk);
        wait_cycles = 4'd3; acc_be = 4'hF;
        d = 32'h1234_5678;
        lo_wr_req = 1; hi_wr_req = 1; lo_wr_data = d[15:0]; hi_wr_data = d[31:16];
        lo_wr_mask = 16'hFFFF; hi_wr_mask = 16'hFFFF;
        repeat (4) @(negedge clk);
        check(reg_done && reg_err, "R9 error reported", {reg_done, reg_err}, 2'b11);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(hi_wr_err && hi_wr_ack && !lo_wr_err, "R9 error held",
                  {hi_wr_err, hi_wr_ack, lo_wr_err}, 3'b110);
        end
        drop_all();
        @(negedge clk);
        check(!hi_wr_err, "R9 error cleared", hi_wr_err, 0);
        model[15:0] = d[15:0];
        access(1'b0, 1'b0, 32'h0, 4'hF, 4'd1, 1'b0, rd);
        check(rd == model, "R9 errored write blocked", rd, model);

        // R11 request withdrawn during a long wait
        @(negedge clk);
        wait_cycles = 4'd10; lo_rd_req = 1; hi_rd_req = 1;
        repeat (3) @(negedge clk);
        drop_all();
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            check(!(lo_rd_ack | hi_rd_ack), "R11 no ack", {lo_rd_ack, hi_rd_ack}, 0);
        end

        // R10 reset in mid-run clears storage
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model = '0;
        access(1'b0, 1'b0, 32'h0, 4'hF, 4'd0, 1'b0, rd);
        check(rd == 32'h0, "R10 cleared", rd, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule